// File: doc/BRIEF.md
# Warm Reset Sequencer

This block steps a microcontroller core through a warm reset. It runs on the CPU clock and watches an active-low reset pin. It acts on that pin only while a supply-level-good flag is high. A low level that lasts long enough is accepted. The block then places the I/O in high impedance, drives its own reset output low and runs a short abort window so that bus activity can wind down. It then holds the core in internal reset for a minimum period. That period is stretched for as long as the pin stays low. Next it strobes the capture of the start-up configuration and releases reset. The core then restarts from a fixed vector.

A clock-mode flag sets how long the block waits from the pin's release to the configuration strobe. Software can arm a pulldown on the reset pin before a reset. The pulldown is active only during a sequence that started while it was armed, and completing a sequence disarms it. If the supply flag falls while the pin is low, the block gives up the warm sequence at once and raises a request for the cold-reset path.

Top module: `warm_reset_seq`

## Requirements
- R1: A warm reset starts only while `supply_ok` is 1. The synchronised pin must also be seen low on at least MIN_LOW (default 2) consecutive clocks. A pin low pulse of one clock, or a low pin while `supply_ok` is 0, leaves every sequence output at its idle value.
- R2: When a reset is accepted, `io_hiz` goes to 1 and `rst_out_n` goes to 0. This happens 3 clocks after the first clock edge that captures the low pin: two synchroniser stages plus one filter stage.
- R3: `bus_abort` is 1 for exactly ABORT_CYC (default 6) clocks, starting in the clock where the reset is accepted. `core_rst` rises in the clock after the window ends.
- R4: `core_rst` stays 1 for at least MIN_RESET (default 512) clocks.
- R5: At the end of the minimum period the synchronised pin is sampled. If it is still low, `core_rst` stays 1 until the pin is seen high.
- R6: `cfg_latch` is a pulse of one clock. It comes N clocks after the first edge at which the pin is seen high once the minimum period is over. N is 3 when `mode_byp_div2` is 1 and 4 when it is 0.
- R7: One clock after `cfg_latch`, the signals `core_rst`, `io_hiz` and `bus_abort` are 0 and `rst_out_n` is 1. In that same clock, `boot_valid` is 1 for one clock and `boot_addr` holds the restart vector 0.
- R8: If `supply_ok` is 0 while the synchronised pin is low, `cold_req` is 1 in the next clock. Any warm sequence in progress is dropped in that same clock, so `io_hiz` and `core_rst` return to 0.
- R9: A one-clock pulse on `sw_pd_set` arms the pin pulldown. `pin_pulldown` is 1 for the whole of a sequence that starts while the pulldown is armed, and 0 otherwise. A completed sequence disarms it.
- R10: While `io_hiz` is 1, the bus strobe outputs are held inactive (`ale_o`=0, `rd_n_o`=1, `rw_n_o`=1). At all other times they pass their inputs through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high power-on override |
| pin_rst_n | input | 1 | Asynchronous reset pin, active low |
| supply_ok | input | 1 | Supply level is above the warm-reset threshold |
| mode_byp_div2 | input | 1 | 1 when the PLL is bypassed with the divide-by-2 prescaler |
| sw_pd_set | input | 1 | Software pulse that arms the pin pulldown |
| ale_i | input | 1 | Address latch strobe from the bus controller |
| rd_n_i | input | 1 | Read strobe from the bus controller, active low |
| rw_n_i | input | 1 | Write strobe from the bus controller, active low |
| core_rst | output | 1 | Internal reset to the core |
| rst_out_n | output | 1 | Reset output pin, active low |
| io_hiz | output | 1 | Puts the I/O pins in high impedance |
| bus_abort | output | 1 | Abort window: cancel holds and end bus cycles |
| pin_pulldown | output | 1 | Enables the reset-pin pulldown |
| cfg_latch | output | 1 | Strobe that captures the start-up configuration |
| cold_req | output | 1 | Request for the cold-reset path |
| boot_valid | output | 1 | Pulse that marks the restart |
| boot_addr | output | VEC_W | Restart vector |
| ale_o | output | 1 | Gated address latch strobe |
| rd_n_o | output | 1 | Gated read strobe |
| rw_n_o | output | 1 | Gated write strobe |

## Verification
Every phase boundary is a fixed number of clocks after the pin edge. A state machine that leaves a phase one clock early or late therefore moves the edges of `bus_abort`, `core_rst` or `cfg_latch` by one clock, and the bench checks every clock of every run. A bad filter count shows up within three clocks of a short pulse as an unexpected `io_hiz`. An enable bit that is never cleared shows up as `pin_pulldown` in the next sequence. A clock-mode decode that is wrong moves the strobe by one clock. A lost abandon path shows up as `core_rst` still high one clock after the supply falls.

// File: rtl/warm_reset_pkg.sv
package warm_reset_pkg;

  // Sequencer phases in the order they are walked through.
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_QUAL   = 3'd1,
    ST_ABORT  = 3'd2,
    ST_HOLD   = 3'd3,
    ST_EXTEND = 3'd4,
    ST_LATCH  = 3'd5,
    ST_STROBE = 3'd6
  } wrs_state_e;

  function automatic logic in_sequence(wrs_state_e s);
    return (s == ST_ABORT) || (s == ST_HOLD) || (s == ST_EXTEND) ||
           (s == ST_LATCH) || (s == ST_STROBE);
  endfunction

  function automatic logic in_core_reset(wrs_state_e s);
    return (s == ST_HOLD) || (s == ST_EXTEND) || (s == ST_LATCH) ||
           (s == ST_STROBE);
  endfunction

endpackage

// File: rtl/wrs_sync.sv
module wrs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          chain[g] <= 1'b1;
        end else if (g == 0) begin
          chain[g] <= async_in;
        end else begin
          chain[g] <= chain[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/wrs_timer.sv
module wrs_timer #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (cnt != {CW{1'b1}}) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wrs_fsm.sv
module wrs_fsm
  import warm_reset_pkg::*;
#(
  parameter int MIN_LOW   = 2,
  parameter int ABORT_CYC = 6,
  parameter int MIN_RESET = 512,
  parameter int LAT_BYP   = 3,
  parameter int LAT_PLL   = 4,
  parameter int CW        = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pin_low,
  input  logic          supply_ok,
  input  logic          mode_byp_div2,
  input  logic [CW-1:0] cnt,
  output wrs_state_e    state,
  output wrs_state_e    nxt,
  output logic          timer_clr
);
  localparam logic [CW-1:0] QUAL_LAST  = CW'(MIN_LOW - 2);
  localparam logic [CW-1:0] ABORT_LAST = CW'(ABORT_CYC - 1);
  localparam logic [CW-1:0] HOLD_LAST  = CW'(MIN_RESET - 1);
  localparam logic [CW-1:0] BYP_LAST   = CW'(LAT_BYP - 1);
  localparam logic [CW-1:0] PLL_LAST   = CW'(LAT_PLL - 1);

  logic [CW-1:0] latch_last;
  logic          cold_hit;

  assign latch_last = mode_byp_div2 ? BYP_LAST : PLL_LAST;
  assign cold_hit   = !supply_ok && pin_low;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:   if (supply_ok && pin_low) nxt = ST_QUAL;
      ST_QUAL: begin
        if (!pin_low)              nxt = ST_IDLE;
        else if (cnt == QUAL_LAST) nxt = ST_ABORT;
      end
      ST_ABORT:  if (cnt == ABORT_LAST) nxt = ST_HOLD;
      ST_HOLD:   if (cnt == HOLD_LAST) nxt = pin_low ? ST_EXTEND : ST_LATCH;
      ST_EXTEND: if (!pin_low) nxt = ST_LATCH;
      ST_LATCH:  if (cnt == latch_last) nxt = ST_STROBE;
      ST_STROBE: nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
    if (cold_hit) nxt = ST_IDLE;
  end

  assign timer_clr = (nxt != state);

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    state inside {ST_IDLE, ST_QUAL, ST_ABORT, ST_HOLD, ST_EXTEND, ST_LATCH, ST_STROBE}); // R1
  AST_NO_START_LOW_SUPPLY: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !supply_ok) |=> state == ST_IDLE); // R1
endmodule

// File: rtl/warm_reset_seq.sv
module warm_reset_seq
  import warm_reset_pkg::*;
#(
  parameter int MIN_LOW     = 2,
  parameter int ABORT_CYC   = 6,
  parameter int MIN_RESET   = 512,
  parameter int LAT_BYP     = 3,
  parameter int LAT_PLL     = 4,
  parameter int SYNC_STAGES = 2,
  parameter int VEC_W       = 24,
  parameter logic [VEC_W-1:0] RESET_VEC = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin_rst_n,
  input  logic             supply_ok,
  input  logic             mode_byp_div2,
  input  logic             sw_pd_set,
  input  logic             ale_i,
  input  logic             rd_n_i,
  input  logic             rw_n_i,
  output logic             core_rst,
  output logic             rst_out_n,
  output logic             io_hiz,
  output logic             bus_abort,
  output logic             pin_pulldown,
  output logic             cfg_latch,
  output logic             cold_req,
  output logic             boot_valid,
  output logic [VEC_W-1:0] boot_addr,
  output logic             ale_o,
  output logic             rd_n_o,
  output logic             rw_n_o
);
  localparam int M1    = (MIN_RESET > ABORT_CYC) ? MIN_RESET : ABORT_CYC;
  localparam int M2    = (M1 > LAT_PLL) ? M1 : LAT_PLL;
  localparam int M3    = (M2 > LAT_BYP) ? M2 : LAT_BYP;
  localparam int MAXC  = (M3 > MIN_LOW) ? M3 : MIN_LOW;
  localparam int CW    = $clog2(MAXC + 1);

  logic          pin_sync;
  logic          pin_low;
  logic [CW-1:0] cnt;
  logic          timer_clr;
  wrs_state_e    state;
  wrs_state_e    nxt;
  logic          pd_armed;
  logic          seq_nxt;

  wrs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pin_rst_n),
    .sync_out (pin_sync)
  );

  assign pin_low = !pin_sync;

  wrs_timer #(.CW(CW)) u_timer (
    .clk (clk),
    .rst (rst),
    .clr (timer_clr),
    .cnt (cnt)
  );

  wrs_fsm #(
    .MIN_LOW   (MIN_LOW),
    .ABORT_CYC (ABORT_CYC),
    .MIN_RESET (MIN_RESET),
    .LAT_BYP   (LAT_BYP),
    .LAT_PLL   (LAT_PLL),
    .CW        (CW)
  ) u_fsm (
    .clk           (clk),
    .rst           (rst),
    .pin_low       (pin_low),
    .supply_ok     (supply_ok),
    .mode_byp_div2 (mode_byp_div2),
    .cnt           (cnt),
    .state         (state),
    .nxt           (nxt),
    .timer_clr     (timer_clr)
  );

  assign seq_nxt = in_sequence(nxt);

  // Pulldown arm bit: set by software, dropped when a sequence completes.
  always_ff @(posedge clk) begin
    if (rst)                     pd_armed <= 1'b0;
    else if (state == ST_STROBE) pd_armed <= 1'b0;
    else if (sw_pd_set)          pd_armed <= 1'b1;
  end

  // Outputs registered from the next-state decode.
  always_ff @(posedge clk) begin
    if (rst) begin
      core_rst     <= 1'b0;
      rst_out_n    <= 1'b1;
      io_hiz       <= 1'b0;
      bus_abort    <= 1'b0;
      pin_pulldown <= 1'b0;
      cfg_latch    <= 1'b0;
      cold_req     <= 1'b0;
      boot_valid   <= 1'b0;
    end else begin
      core_rst     <= in_core_reset(nxt);
      rst_out_n    <= !seq_nxt;
      io_hiz       <= seq_nxt;
      bus_abort    <= (nxt == ST_ABORT);
      pin_pulldown <= seq_nxt && pd_armed && (state != ST_STROBE);
      cfg_latch    <= (nxt == ST_STROBE);
      cold_req     <= !supply_ok && pin_low;
      boot_valid   <= (state == ST_STROBE) && (nxt == ST_IDLE);
    end
  end

  assign boot_addr = RESET_VEC;
  assign ale_o     = ale_i  && !io_hiz;
  assign rd_n_o    = rd_n_i || io_hiz;
  assign rw_n_o    = rw_n_i || io_hiz;

  AST_ABORT_BEFORE_CORE: assert property (@(posedge clk) disable iff (rst)
    $rose(core_rst) |-> $past(bus_abort)); // R3
  AST_CORE_IN_HIZ: assert property (@(posedge clk) disable iff (rst)
    core_rst |-> (io_hiz && !rst_out_n)); // R4
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (rst)
    cfg_latch |=> !cfg_latch); // R6
  AST_RELEASE_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
    cfg_latch |=> (!core_rst && rst_out_n && !io_hiz && boot_valid)); // R7
  AST_COLD_ABANDON: assert property (@(posedge clk) disable iff (rst)
    cold_req |-> (!io_hiz && !core_rst)); // R8
  AST_PD_IN_SEQ: assert property (@(posedge clk) disable iff (rst)
    pin_pulldown |-> io_hiz); // R9
endmodule

// File: tb/tb_warm_reset_seq.sv
module tb_warm_reset_seq;
  localparam int MINR = 512;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pin_rst_n = 1'b1;
  logic supply_ok = 1'b1;
  logic mode_byp_div2 = 1'b0;
  logic sw_pd_set = 1'b0;
  logic ale_i = 1'b1;
  logic rd_n_i = 1'b0;
  logic rw_n_i = 1'b0;
  logic core_rst, rst_out_n, io_hiz, bus_abort, pin_pulldown, cfg_latch;
  logic cold_req, boot_valid, ale_o, rd_n_o, rw_n_o;
  logic [23:0] boot_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit pd_model = 0;

  always #4 clk = ~clk;

  warm_reset_seq dut (
    .clk(clk), .rst(rst), .pin_rst_n(pin_rst_n), .supply_ok(supply_ok),
    .mode_byp_div2(mode_byp_div2), .sw_pd_set(sw_pd_set),
    .ale_i(ale_i), .rd_n_i(rd_n_i), .rw_n_i(rw_n_i),
    .core_rst(core_rst), .rst_out_n(rst_out_n), .io_hiz(io_hiz),
    .bus_abort(bus_abort), .pin_pulldown(pin_pulldown), .cfg_latch(cfg_latch),
    .cold_req(cold_req), .boot_valid(boot_valid), .boot_addr(boot_addr),
    .ale_o(ale_o), .rd_n_o(rd_n_o), .rw_n_o(rw_n_o)
  );

  task automatic chk(string tag, logic act, logic exp, int t);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0d actual=%b expected=%b", tag, t, act, exp);
    end
  endtask

  // One sequence: pin low for len clocks. t counts edges after the first
  // edge that captures the low pin.
  task automatic run_seq(int len, bit mode, bit pd_req);
    bit acc;
    int n, e, last;
    bit seq;
    string tg;
    if (pd_req) begin
      @(negedge clk) sw_pd_set = 1'b1;
      @(negedge clk) sw_pd_set = 1'b0;
      pd_model = 1'b1;
    end
    @(negedge clk) mode_byp_div2 = mode;
    acc  = (len >= 2);
    n    = mode ? 3 : 4;
    e    = (len + 2 > MINR + 9) ? len + 2 : MINR + 9;
    last = acc ? e + n + 3 : len + 4;
    @(negedge clk) pin_rst_n = 1'b0;
    for (int t = 0; t <= last; t++) begin
      @(posedge clk);
      #1;
      seq = acc && t >= 3 && t <= e + n;
      tg  = acc ? "R2" : "R1";
      chk({tg, " io_hiz"}, io_hiz, seq, t);
      chk({tg, " rst_out_n"}, rst_out_n, !seq, t);
      chk("R3 bus_abort", bus_abort, acc && t >= 3 && t <= 8, t);
      tg = (len + 2 > MINR + 9) ? "R5" : "R4";
      chk({tg, " core_rst"}, core_rst, acc && t >= 9 && t <= e + n, t);
      chk("R6 cfg_latch", cfg_latch, acc && t == e + n, t);
      chk("R7 boot_valid", boot_valid, acc && t == e + n + 1, t);
      chk("R9 pin_pulldown", pin_pulldown, seq && pd_model, t);
      chk("R10 ale_o", ale_o, !seq, t);
      chk("R10 rd_n_o", rd_n_o, seq, t);
      chk("R10 rw_n_o", rw_n_o, seq, t);
      chk("R8 cold_req", cold_req, 1'b0, t);
      if (acc && t == e + n + 1) begin
        checks++;
        if (boot_addr !== 24'h0) begin
          errors++;
          $display("FAIL R7 boot_addr actual=%h expected=000000", boot_addr);
        end
      end
      if (t == len - 1) pin_rst_n = 1'b1;
    end
    if (acc) pd_model = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int lens[9] = '{1, 2, 3, 5, 40, 519, 520, 521, 530};
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(posedge clk); #1;
    chk("R2 reset io_hiz", io_hiz, 1'b0, 0);
    chk("R2 reset rst_out_n", rst_out_n, 1'b1, 0);
    chk("R4 reset core_rst", core_rst, 1'b0, 0);
    chk("R6 reset cfg_latch", cfg_latch, 1'b0, 0);
    chk("R8 reset cold_req", cold_req, 1'b0, 0);
    chk("R9 reset pin_pulldown", pin_pulldown, 1'b0, 0);

    for (int m = 0; m < 2; m++)
      for (int i = 0; i < 9; i++)
        for (int p = 0; p < 2; p++)
          run_seq(lens[i], m[0], p[0]);

    // R1: low pin with supply low never starts a warm sequence.
    @(negedge clk) supply_ok = 1'b0;
    @(negedge clk) pin_rst_n = 1'b0;
    for (int t = 0; t < 20; t++) begin
      @(posedge clk); #1;
      chk("R1 io_hiz with supply low", io_hiz, 1'b0, t);
      if (t >= 2) chk("R8 cold_req with supply low", cold_req, 1'b1, t);
    end
    @(negedge clk) pin_rst_n = 1'b1;
    repeat (4) @(negedge clk);
    supply_ok = 1'b1;
    repeat (4) @(negedge clk);

    // R8: supply drops in the middle of the minimum period.
    pin_rst_n = 1'b0;
    for (int t = 0; t <= 101; t++) begin
      @(posedge clk); #1;
      if (t == 100) begin
        chk("R8 core_rst before drop", core_rst, 1'b1, t);
        supply_ok = 1'b0;
      end
      if (t == 101) begin
        chk("R8 cold_req", cold_req, 1'b1, t);
        chk("R8 io_hiz abandoned", io_hiz, 1'b0, t);
        chk("R8 core_rst abandoned", core_rst, 1'b0, t);
      end
    end
    @(negedge clk) pin_rst_n = 1'b1;
    repeat (4) @(negedge clk);
    supply_ok = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk("R8 cold_req cleared", cold_req, 1'b0, 0);
    chk("R8 io_hiz idle", io_hiz, 1'b0, 0);

    // A full sequence still works after the abandon.
    run_seq(3, 1'b1, 1'b1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule